// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel data buses, called the A side and the B side, and can pass data between them in either direction. It has one storage register for each direction. The A-side register takes the A bus value on its own capture clock, and the B-side register takes the B bus value on a second, separate clock. A per-direction source select sends either the live value from the opposite bus or the value held in that direction's register to the outputs.

An active-low drive input and a direction input decide which bus, if any, is driven. The capture clocks are never gated by these two controls, so either register can load at any time, including while both buses are released. Each pad-level tri-state appears as three signals: a data input, a data output and an output enable.

A build parameter chooses whether the outputs carry the source value unchanged or bit-inverted. The data width is a parameter, 8 bits by default. The registers have no reset, so their contents are unknown until their first capture.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On each rising edge of `cap_a_clk` the A register loads `a_din`, and on each rising edge of `cap_b_clk` the B register loads `b_din`.
- R2: While `drive_n` is 1, both `a_oe` and `b_oe` are 0.
- R3: While `drive_n` is 0, `toward_b` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `toward_b` = 0 gives `a_oe` = 1 and `b_oe` = 0. The two enables are never 1 together.
- R4: While `ab_stored` is 0, `b_dout` follows the live `a_din` combinationally, whatever the enables are.
- R5: While `ab_stored` is 1, `b_dout` shows the A register contents.
- R6: `ba_stored` = 0 sends the live `b_din` to `a_dout`, and `ba_stored` = 1 sends the B register contents to `a_dout`.
- R7: A capture takes place whatever the values of `drive_n` and `toward_b`, including while both buses are released or while the capturing bus is itself being driven.
- R8: The two registers hold independent values at the same time. A capture on one clock leaves the other register unchanged.
- R9: With `INVERT` = 0 both data outputs carry the selected source value unchanged. With `INVERT` = 1 they carry its bitwise complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_a_clk | input | 1 | Rising edge loads the A register from `a_din` |
| cap_b_clk | input | 1 | Rising edge loads the B register from `b_din` |
| drive_n | input | 1 | Active-low bus drive enable |
| toward_b | input | 1 | 1 drives the B bus, 0 drives the A bus |
| ab_stored | input | 1 | Source for `b_dout`: 0 live A data, 1 A register |
| ba_stored | input | 1 | Source for `a_dout`: 0 live B data, 1 B register |
| a_din | input | WIDTH | Value seen on the A bus pads |
| a_dout | output | WIDTH | Value to drive onto the A bus |
| a_oe | output | 1 | A bus pad drive enable |
| b_din | input | WIDTH | Value seen on the B bus pads |
| b_dout | output | WIDTH | Value to drive onto the B bus |
| b_oe | output | 1 | B bus pad drive enable |

## Verification
At every capture edge the assertions check the enable decode: both enables are released when `drive_n` is high, exactly one enable follows `toward_b` otherwise, and the two are never on together. At the same edges they check that live-mode outputs match the opposite bus with the chosen polarity, and that stored-mode outputs match the value the bus held at the previous capture edge. Only the bench scenarios can show that one register keeps its value while the other captures, that a capture works while either bus is driven or both are released, and that the inverting build complements every bit in all four source paths.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Source selection for one transfer direction.
  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_HELD = 1'b1
  } src_e;

  // Output polarity applied after the source mux.
  function automatic logic [63:0] pol_mask(input bit invert);
    return invert ? {64{1'b1}} : 64'd0;
  endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
// Edge-triggered holding register for one transfer direction.
// It has no reset: contents are unknown until the first capture edge.
module xcvr_capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] held;

  always_ff @(posedge clk) begin
    held <= d;
  end

  assign q = held;

endmodule

// File: rtl/xcvr_path.sv
// Source mux plus polarity stage for one transfer direction.
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] held,
  input  src_e             src,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] picked;

  always_comb begin
    unique case (src)
      SRC_HELD: picked = held;
      default:  picked = live;
    endcase
  end

  generate
    if (INVERT) begin : g_inv
      assign dout = ~picked;
    end else begin : g_true
      assign dout = picked;
    end
  endgenerate

endmodule

// File: rtl/xcvr_drive_ctl.sv
// Turns the drive enable and direction into one enable per bus.
module xcvr_drive_ctl (
  input  logic drive_n,
  input  logic toward_b,
  output logic a_oe,
  output logic b_oe
);

  logic active;

  assign active = ~drive_n;
  assign b_oe   = active & toward_b;
  assign a_oe   = active & ~toward_b;

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             cap_a_clk,
  input  logic             cap_b_clk,
  input  logic             drive_n,
  input  logic             toward_b,
  input  logic             ab_stored,
  input  logic             ba_stored,
  input  logic [WIDTH-1:0] a_din,
  output logic [WIDTH-1:0] a_dout,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_din,
  output logic [WIDTH-1:0] b_dout,
  output logic             b_oe
);

  logic [WIDTH-1:0] a_held;
  logic [WIDTH-1:0] b_held;
  src_e             ab_src;
  src_e             ba_src;

  assign ab_src = src_e'(ab_stored);
  assign ba_src = src_e'(ba_stored);

  // R1, R7: capture clocks are independent of the drive controls.
  xcvr_capture_reg #(.WIDTH(WIDTH)) u_a_reg (
    .clk (cap_a_clk),
    .d   (a_din),
    .q   (a_held)
  );

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_b_reg (
    .clk (cap_b_clk),
    .d   (b_din),
    .q   (b_held)
  );

  // A -> B path feeds the B bus outputs.
  xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_ab_path (
    .live (a_din),
    .held (a_held),
    .src  (ab_src),
    .dout (b_dout)
  );

  // B -> A path feeds the A bus outputs.
  xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_ba_path (
    .live (b_din),
    .held (b_held),
    .src  (ba_src),
    .dout (a_dout)
  );

  xcvr_drive_ctl u_ctl (
    .drive_n  (drive_n),
    .toward_b (toward_b),
    .a_oe     (a_oe),
    .b_oe     (b_oe)
  );

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input logic             cap_a_clk,
  input logic             cap_b_clk,
  input logic             drive_n,
  input logic             toward_b,
  input logic             ab_stored,
  input logic             ba_stored,
  input logic [WIDTH-1:0] a_din,
  input logic [WIDTH-1:0] a_dout,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_din,
  input logic [WIDTH-1:0] b_dout,
  input logic             b_oe
);

  localparam logic [WIDTH-1:0] MASK = INVERT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  // Warm-up flags: properties wait for the first edge of their clock.
  logic armed_a = 1'b0;
  logic armed_b = 1'b0;

  always_ff @(posedge cap_a_clk) armed_a <= 1'b1;
  always_ff @(posedge cap_b_clk) armed_b <= 1'b1;

  p_idle_r2: assert property (@(posedge cap_a_clk) disable iff (!armed_a)
    drive_n |-> (!a_oe && !b_oe));

  p_one_bus_r3: assert property (@(posedge cap_a_clk) disable iff (!armed_a)
    !(a_oe && b_oe));

  p_dir_r3: assert property (@(posedge cap_b_clk) disable iff (!armed_b)
    !drive_n |-> ((b_oe == toward_b) && (a_oe == !toward_b)));

  p_live_ab_r4: assert property (@(posedge cap_a_clk) disable iff (!armed_a)
    !ab_stored |-> (b_dout == (a_din ^ MASK)));

  p_held_ab_r5: assert property (@(posedge cap_a_clk) disable iff (!armed_a)
    ab_stored |-> (b_dout == ($past(a_din) ^ MASK)));

  p_live_ba_r6: assert property (@(posedge cap_b_clk) disable iff (!armed_b)
    !ba_stored |-> (a_dout == (b_din ^ MASK)));

  p_held_ba_r6: assert property (@(posedge cap_b_clk) disable iff (!armed_b)
    ba_stored |-> (a_dout == ($past(b_din) ^ MASK)));

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (
  .cap_a_clk (cap_a_clk),
  .cap_b_clk (cap_b_clk),
  .drive_n   (drive_n),
  .toward_b  (toward_b),
  .ab_stored (ab_stored),
  .ba_stored (ba_stored),
  .a_din     (a_din),
  .a_dout    (a_dout),
  .a_oe      (a_oe),
  .b_din     (b_din),
  .b_dout    (b_dout),
  .b_oe      (b_oe)
);

// File: tb/sim_bus_xcvr_reg.sv
`timescale 1ns/1ps
module sim_bus_xcvr_reg;

  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         cap_a_clk = 1'b0;
  logic         cap_b_clk = 1'b0;
  logic         drive_n   = 1'b1;
  logic         toward_b  = 1'b0;
  logic         ab_stored = 1'b0;
  logic         ba_stored = 1'b0;
  logic [W-1:0] a_din     = '0;
  logic [W-1:0] b_din     = '0;

  logic [W-1:0] a_dout0, b_dout0, a_dout1, b_dout1;
  logic         a_oe0, b_oe0, a_oe1, b_oe1;

  int checks = 0;
  int fails  = 0;

  // Bench-side view of the two register contents.
  logic [W-1:0] m_a;
  logic [W-1:0] m_b;

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b0)) u0 (
    .cap_a_clk, .cap_b_clk, .drive_n, .toward_b, .ab_stored, .ba_stored,
    .a_din, .a_dout(a_dout0), .a_oe(a_oe0),
    .b_din, .b_dout(b_dout0), .b_oe(b_oe0)
  );

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b1)) u1 (
    .cap_a_clk, .cap_b_clk, .drive_n, .toward_b, .ab_stored, .ba_stored,
    .a_din, .a_dout(a_dout1), .a_oe(a_oe1),
    .b_din, .b_dout(b_dout1), .b_oe(b_oe1)
  );

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] exp_b_out(input bit inv);
    logic [W-1:0] v;
    v = ab_stored ? m_a : a_din;
    return inv ? ~v : v;
  endfunction

  function automatic logic [W-1:0] exp_a_out(input bit inv);
    logic [W-1:0] v;
    v = ba_stored ? m_b : b_din;
    return inv ? ~v : v;
  endfunction

  task automatic pulse_a();
    #2 cap_a_clk = 1'b1;
    m_a = a_din;
    #2 cap_a_clk = 1'b0;
    #1;
  endtask

  task automatic pulse_b();
    #2 cap_b_clk = 1'b1;
    m_b = b_din;
    #2 cap_b_clk = 1'b0;
    #1;
  endtask

  task automatic check_all(input string tag);
    #1;
    check({tag, " R3 a_oe"}, {7'd0, a_oe0}, {7'd0, (!drive_n && !toward_b)});
    check({tag, " R3 b_oe"}, {7'd0, b_oe0}, {7'd0, (!drive_n && toward_b)});
    check({tag, " R3 both"}, {7'd0, a_oe0 & b_oe0}, 8'd0);
    check({tag, " R5 b_dout"}, b_dout0, exp_b_out(1'b0));
    check({tag, " R6 a_dout"}, a_dout0, exp_a_out(1'b0));
    check({tag, " R9 inv b_dout"}, b_dout1, exp_b_out(1'b1));
    check({tag, " R9 inv a_dout"}, a_dout1, exp_a_out(1'b1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);

    // Idle state: nothing driven, live paths pass through.
    a_din = 8'h5A; b_din = 8'hC3; #3;
    check("R2 a_oe idle", {7'd0, a_oe0}, 8'd0);
    check("R2 b_oe idle", {7'd0, b_oe0}, 8'd0);
    check("R4 live b_dout", b_dout0, 8'h5A);
    check("R6 live a_dout", a_dout0, 8'hC3);
    check("R9 inverted live b_dout", b_dout1, 8'hA5);

    // R7, R8: load both registers while both buses are released.
    a_din = 8'hA5; pulse_a();
    b_din = 8'h3C; pulse_b();
    a_din = 8'h00; b_din = 8'hFF;
    ab_stored = 1'b1; ba_stored = 1'b1; #1;
    check("R1 R7 A reg via b_dout", b_dout0, 8'hA5);
    check("R1 R7 B reg via a_dout", a_dout0, 8'h3C);
    check("R9 inverted A reg", b_dout1, 8'h5A);
    check("R9 inverted B reg", a_dout1, 8'hC3);

    // R7: capture A while the A bus itself is being driven.
    drive_n = 1'b0; toward_b = 1'b0; #1;
    check("R3 dir low a_oe", {7'd0, a_oe0}, 8'd1);
    check("R3 dir low b_oe", {7'd0, b_oe0}, 8'd0);
    a_din = 8'h71; pulse_a();
    check("R7 capture under drive", b_dout0, 8'h71);
    check("R8 B reg untouched", a_dout0, 8'h3C);

    // R8: capture B, A must stay.
    toward_b = 1'b1; b_din = 8'h0F; pulse_b();
    check("R8 A reg untouched", b_dout0, 8'h71);
    check("R1 B reg new value", a_dout0, 8'h0F);
    check("R3 dir high b_oe", {7'd0, b_oe0}, 8'd1);

    // R4: live mode follows input changes without any clock.
    ab_stored = 1'b0; a_din = 8'h99; #1;
    check("R4 live follows", b_dout0, 8'h99);
    a_din = 8'h12; #1;
    check("R4 live follows again", b_dout0, 8'h12);

    // Random mix.
    for (int i = 0; i < 400; i++) begin
      a_din     = W'($urandom);
      b_din     = W'($urandom);
      drive_n   = 1'($urandom);
      toward_b  = 1'($urandom);
      ab_stored = 1'($urandom);
      ba_stored = 1'($urandom);
      if (($urandom % 3) == 0) pulse_a();
      if (($urandom % 3) == 0) pulse_b();
      a_din = W'($urandom);
      b_din = W'($urandom);
      check_all("rand");
      if (drive_n) begin
        check("R2 rand a_oe", {7'd0, a_oe0}, 8'd0);
        check("R2 rand b_oe", {7'd0, b_oe0}, 8'd0);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule